// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer behind a 10-bit successive-approximation converter. The sample/hold switch, the resistor-string DAC and the comparator sit outside it. The block steps them through one conversion: a timed sample phase, then one binary-search trial per result bit. Each trial drives a tap code to the DAC and reads back a single comparator bit. When the last bit is decided, the finished code is copied into a result register and an end-of-conversion interrupt fires.

Two start policies are offered. In software mode, raising the enable input starts a conversion at once. Further conversions then follow back to back for as long as enable stays high. In timer mode, enable only arms the block, and each conversion waits for a rising edge on a timer trigger input. The length of the sample phase and the length of each trial are both set by inputs. A trial lasts long enough for the DAC and the comparator to settle, and the comparator is looked at only at the end of the trial.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is held and after reset, `sample_on`, `hold` and `eoc_irq` are 0, and `dac_code` and `result` are 0.
- R2: With `trig_mode`=0, raising `enable` starts a conversion on the next clock. The sample phase lasts max(1,`samp_len`) cycles, with `sample_on`=1 and `hold`=0, and `sample_on` and `hold` are never both 1.
- R3: After the sample phase, `hold` stays 1 for exactly 10·max(1,`trial_len`) cycles, one trial per bit. The first trial drives `dac_code`=0x200. The second trial drives 0x300 if bit 9 was kept and 0x100 if it was cleared. Outside trials `dac_code` is 0.
- R4: The comparator bit `cmp_in`=1 means the input is at or above the current tap, and the trial bit is then kept; otherwise it is cleared. `cmp_in` is sampled only on the last clock of each trial. For an input level v in 0..1023, the result is v.
- R5: The clock that decides bit 0 loads `result` and raises `eoc_irq` for exactly one cycle. The first `eoc_irq` is seen S+10·T cycles after the starting clock edge, where S and T are the effective lengths. `result` changes only together with `eoc_irq`.
- R6: In software mode with `enable` still 1, the next conversion starts straight after completion, so `eoc_irq` repeats every S+10·T cycles.
- R7: With `trig_mode`=1, `enable` only arms the block, and no sampling or trial occurs. A conversion starts on the clock that sees `tmr_trig` go from 0 to 1.
- R8: In timer mode, a trigger edge during a conversion is ignored. After completion the block waits for a new trigger edge for as long as `enable` stays 1.
- R9: Lowering `enable` aborts any conversion: on the next clock `hold` and `sample_on` are 0, no `eoc_irq` follows, and `result` keeps its value.
- R10: A `samp_len` or `trial_len` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; low aborts and idles |
| trig_mode | input | 1 | 0 = software start, 1 = timer-trigger start |
| samp_len | input | LEN_W (8) | Sample phase length in clocks |
| trial_len | input | LEN_W (8) | Clocks per bit trial |
| tmr_trig | input | 1 | External timer trigger, rising edge starts a conversion |
| cmp_in | input | 1 | Comparator: 1 when input ≥ tap |
| sample_on | output | 1 | Sample switch closed |
| hold | output | 1 | Hold asserted during bit trials |
| dac_code | output | RES_W (10) | Tap code for the resistor-string DAC |
| result | output | RES_W (10) | Last completed conversion |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Some properties are checked by assertions on every cycle. `sample_on` and `hold` never overlap. Each trial sequence opens at the half-scale code. The interrupt lasts one cycle and comes only from a clock where `hold` was high. `result` never moves without the interrupt. Dropping enable clears both phase outputs on the next clock. Other behaviours only the bench scenarios can show. These are the phase lengths, the exact latency and repeat period, the binary-search outcome against a modelled analog input, and the fact that the comparator is read only at the end of a trial. The bench's comparator model gives wrong answers until the tap has been stable for a whole trial, which exposes early sampling. The scenarios also cover trigger edges that are ignored during a conversion, and the result kept across an abort.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_TRIAL  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/sar_trig_edge.sv
module sar_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);

    typedef struct packed {
        logic prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = trig_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign trig_rise = trig_in & ~r_q.prev;

endmodule

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             last
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            // a programmed length of zero is stretched to one clock
            r_d.cnt = (load_val == '0) ? ONE : load_val;
        end else if (r_q.cnt > ONE) begin
            r_d.cnt = r_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign last = (r_q.cnt <= ONE);

endmodule

// File: rtl/sar_bit_core.sv
module sar_bit_core #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             decide,
    input  logic             cmp_in,
    output logic [RES_W-1:0] sar,
    output logic [RES_W-1:0] result,
    output logic             eoc
);

    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_W - 1);
    localparam logic [RES_W-1:0] LSB_ONE = RES_W'(1);
    localparam logic [RES_W-1:0] MSB_ONE = LSB_ONE << (RES_W - 1);

    typedef struct packed {
        logic [RES_W-1:0] sar;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] result;
        logic             eoc;
    } core_regs_t;

    core_regs_t r_d, r_q;

    logic [RES_W-1:0] bit_mask;
    logic [RES_W-1:0] next_mask;
    logic [RES_W-1:0] decided;

    always_comb begin
        bit_mask  = LSB_ONE << r_q.idx;
        next_mask = bit_mask >> 1;
        // the trial bit survives only when the input is at or above the tap
        decided   = cmp_in ? r_q.sar : (r_q.sar & ~bit_mask);

        r_d     = r_q;
        r_d.eoc = 1'b0;
        if (start) begin
            r_d.sar = MSB_ONE;
            r_d.idx = MSB_IDX;
        end else if (decide) begin
            if (r_q.idx == '0) begin
                r_d.sar    = decided;
                r_d.result = decided;
                r_d.eoc    = 1'b1;
            end else begin
                r_d.sar = decided | next_mask;
                r_d.idx = r_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sar    = r_q.sar;
    assign result = r_q.result;
    assign eoc    = r_q.eoc;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_W = 10,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig_mode,
    input  logic [LEN_W-1:0] samp_len,
    input  logic [LEN_W-1:0] trial_len,
    input  logic             tmr_trig,
    input  logic             cmp_in,
    output logic             sample_on,
    output logic             hold,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             eoc_irq
);

    import sar_seq_pkg::*;

    seq_regs_t r_d, r_q;

    logic             trig_rise;
    logic             tmr_last;
    logic             tmr_load;
    logic [LEN_W-1:0] tmr_val;
    logic             core_start;
    logic             core_decide;
    logic             core_eoc;
    logic [RES_W-1:0] sar_val;
    logic             final_trial;
    logic [RES_W-1:0] lsb_mask;

    sar_trig_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (tmr_trig),
        .trig_rise (trig_rise)
    );

    sar_phase_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sar_bit_core #(.RES_W(RES_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (core_start),
        .decide (core_decide),
        .cmp_in (cmp_in),
        .sar    (sar_val),
        .result (result),
        .eoc    (core_eoc)
    );

    // the last trial is the one whose lowest set bit is bit 0
    assign lsb_mask    = RES_W'(1);
    assign final_trial = |(sar_val & lsb_mask);

    always_comb begin
        r_d         = r_q;
        tmr_load    = 1'b0;
        tmr_val     = trial_len;
        core_start  = 1'b0;
        core_decide = 1'b0;

        if (!enable) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (!trig_mode) begin
                        r_d.state = ST_SAMPLE;
                        tmr_load  = 1'b1;
                        tmr_val   = samp_len;
                    end else begin
                        r_d.state = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (trig_rise) begin
                        r_d.state = ST_SAMPLE;
                        tmr_load  = 1'b1;
                        tmr_val   = samp_len;
                    end
                end
                ST_SAMPLE: begin
                    if (tmr_last) begin
                        r_d.state  = ST_TRIAL;
                        tmr_load   = 1'b1;
                        tmr_val    = trial_len;
                        core_start = 1'b1;
                    end
                end
                ST_TRIAL: begin
                    if (tmr_last) begin
                        core_decide = 1'b1;
                        tmr_load    = 1'b1;
                        if (final_trial) begin
                            if (trig_mode) begin
                                r_d.state = ST_ARMED;
                            end else begin
                                r_d.state = ST_SAMPLE;
                                tmr_val   = samp_len;
                            end
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign sample_on = (r_q.state == ST_SAMPLE);
    assign hold      = (r_q.state == ST_TRIAL);
    assign dac_code  = hold ? sar_val : '0;
    assign eoc_irq   = core_eoc;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sample_on,
    input logic             hold,
    input logic [RES_W-1:0] dac_code,
    input logic [RES_W-1:0] result,
    input logic             eoc_irq
);

    localparam logic [RES_W-1:0] HALF_CODE = RES_W'(1) << (RES_W - 1);

    // R2
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && sample_on));

    // R3
    first_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (dac_code == HALF_CODE));

    // R5
    eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    // R5
    eoc_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> $past(hold));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> eoc_irq);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hold && !sample_on && !eoc_irq));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sample_on (sample_on),
    .hold      (hold),
    .dac_code  (dac_code),
    .result    (result),
    .eoc_irq   (eoc_irq)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;

    localparam int RES_W = 10;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             trig_mode = 1'b0;
    logic [LEN_W-1:0] samp_len = 8'd2;
    logic [LEN_W-1:0] trial_len = 8'd2;
    logic             tmr_trig = 1'b0;
    logic             cmp_in;
    logic             sample_on;
    logic             hold;
    logic [RES_W-1:0] dac_code;
    logic [RES_W-1:0] result;
    logic             eoc_irq;

    int checks = 0;
    int failures = 0;
    int vin = 0;

    always #5 clk = ~clk;

    sar_conv_seq #(.RES_W(RES_W), .LEN_W(LEN_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .trig_mode (trig_mode),
        .samp_len  (samp_len),
        .trial_len (trial_len),
        .tmr_trig  (tmr_trig),
        .cmp_in    (cmp_in),
        .sample_on (sample_on),
        .hold      (hold),
        .dac_code  (dac_code),
        .result    (result),
        .eoc_irq   (eoc_irq)
    );

    // Analog model: the comparator answers wrongly until the tap has been
    // stable for a whole trial, so early sampling gives a wrong result.
    int tlen_eff;
    int settle = 0;
    logic [RES_W-1:0] prev_code = '0;
    assign tlen_eff = (trial_len == 0) ? 1 : int'(trial_len);
    assign cmp_in = (settle >= tlen_eff - 1) ? (vin >= int'(dac_code))
                                             : !(vin >= int'(dac_code));

    // phase-length and trial-code monitor
    int samp_run = 0, hold_run = 0, samp_last = 0, hold_last = 0;
    int code0 = 0, code1 = 0;
    always @(negedge clk) begin
        if (dac_code != prev_code) settle = 0;
        else if (settle < 1000) settle = settle + 1;
        prev_code = dac_code;
        if (sample_on) samp_run = samp_run + 1;
        else if (samp_run != 0) begin samp_last = samp_run; samp_run = 0; end
        if (hold) begin
            hold_run = hold_run + 1;
            if (hold_run == 1) code0 = int'(dac_code);
            if (hold_run == tlen_eff + 1) code1 = int'(dac_code);
        end else if (hold_run != 0) begin
            hold_last = hold_run;
            hold_run = 0;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_eoc(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n = n + 1;
            if (eoc_irq) return;
        end
        n = -1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable = 1'b0;
        tmr_trig = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!sample_on && !hold && !eoc_irq, "R1 phase outputs in reset",
            {sample_on, hold, eoc_irq}, 0);
        chk(dac_code == 0 && result == 0, "R1 codes in reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sample_on && !hold && !eoc_irq && result == 0, "R1 idle after reset",
            {sample_on, hold, eoc_irq}, 0);
    endtask

    // R2 R3 R4 R5 R6 R10: software-mode conversion and its continuation
    task automatic t_soft(input int v, input int s, input int t);
        int n, se, te, lat;
        se = (s == 0) ? 1 : s;
        te = (t == 0) ? 1 : t;
        lat = se + 10 * te;
        vin = v;
        samp_len = LEN_W'(s);
        trial_len = LEN_W'(t);
        trig_mode = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        wait_eoc(2000, n);
        chk(n == lat + 1, "R5 R10 first eoc latency", n, lat + 1);
        chk(int'(result) == v, "R4 binary-search result", int'(result), v);
        @(negedge clk);
        chk(!eoc_irq, "R5 eoc single cycle", eoc_irq, 0);
        chk(int'(result) == v, "R5 result held after eoc", int'(result), v);
        chk(samp_last == se, "R2 R10 sample phase length", samp_last, se);
        chk(hold_last == 10 * te, "R3 hold length", hold_last, 10 * te);
        chk(code0 == 512, "R3 first tap", code0, 512);
        chk(code1 == ((v >= 512) ? 768 : 256), "R3 second tap", code1,
            (v >= 512) ? 768 : 256);
        wait_eoc(2000, n);
        chk(n == lat - 1, "R6 continuous repeat period", n + 1, lat);
        chk(int'(result) == v, "R6 repeated result", int'(result), v);
        go_idle();
    endtask

    // R7 R8: timer-trigger mode
    task automatic t_timer();
        int n;
        bit busy;
        vin = 300;
        samp_len = 8'd3;
        trial_len = 8'd2;
        trig_mode = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        busy = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sample_on || hold || eoc_irq) busy = 1'b1;
        end
        chk(!busy, "R7 armed block stays quiet", busy, 0);
        tmr_trig = 1'b1;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n = n + 1;
            if (n == 10) tmr_trig = 1'b0;
            if (n == 12) tmr_trig = 1'b1;
            if (eoc_irq) break;
        end
        chk(n == 24, "R7 trigger-to-eoc latency", n, 24);
        chk(int'(result) == 300, "R7 timer result", int'(result), 300);
        busy = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sample_on || hold || eoc_irq) busy = 1'b1;
        end
        chk(!busy, "R8 trigger in flight ignored", busy, 0);
        tmr_trig = 1'b0;
        vin = 777;
        repeat (2) @(negedge clk);
        tmr_trig = 1'b1;
        wait_eoc(200, n);
        chk(n == 24, "R8 re-armed latency", n, 24);
        chk(int'(result) == 777, "R8 re-armed result", int'(result), 777);
        go_idle();
    endtask

    // R9: abort keeps the previous result
    task automatic t_abort();
        int keep;
        bit seen;
        keep = int'(result);
        vin = 100;
        samp_len = 8'd3;
        trial_len = 8'd4;
        trig_mode = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        chk(hold, "R9 conversion under way", hold, 1);
        enable = 1'b0;
        @(negedge clk);
        chk(!hold && !sample_on, "R9 idle one clock after abort",
            {hold, sample_on}, 0);
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (eoc_irq || hold || sample_on) seen = 1'b1;
        end
        chk(!seen, "R9 no completion after abort", seen, 0);
        chk(int'(result) == keep, "R9 result unchanged", int'(result), keep);
    endtask

    initial begin
        t_reset();
        t_soft(0, 2, 2);
        t_soft(1023, 1, 3);
        t_soft(512, 4, 1);
        t_soft(511, 2, 2);
        t_soft(341, 3, 4);
        t_soft(700, 0, 0);
        t_timer();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule